// File: doc/BRIEF.md
# Read-Capture Delay Tap Centring Engine

This engine finds the range of read-capture delay taps over which data is captured correctly, then places the tap in the middle of that range. After a start pulse it takes the supplied tap as its first candidate. It walks upward from there until a trial fails or the ceiling is reached. It then goes back to the start tap and walks downward until a trial fails or tap zero passes. For each trial the candidate is placed on both strobe lanes and an external memory checker is asked for a verdict. The checker does the memory reads and compares them. It answers with a done pulse that carries a pass flag.

When the search is over, lane 0 gets the midpoint of the recorded upper and lower bounds and lane 1 gets the midpoint plus one. A done flag marks the result as ready. A combinational pattern generator, kept or removed by a parameter, gives the checker its reference data words. Each word is taken from an entry index and a word select.

Top module: `dqs_tap_search`

## Requirements
- R1: Before each check request, both lane outputs carry the same candidate tap. They stay unchanged until the checker answers.
- R2: A trial passes only after two check rounds in a row report pass. The first failing round ends the trial, and no further request is made for that tap.
- R3: Upward phase, passing trial: a candidate below 32 moves up by one. A candidate of 32 or more becomes the upper bound, and the next candidate is the start tap with the direction set to downward.
- R4: Upward phase, failing trial: the upper bound becomes the candidate minus one, modulo 64. The next candidate is the start tap, and the direction becomes downward.
- R5: Downward phase, passing trial: the candidate moves down by one. If the candidate is already zero, the lower bound becomes zero and the search ends.
- R6: Downward phase, failing trial: the lower bound becomes the candidate plus one and the search ends.
- R7: At the end, lane 0 is floor((upper + lower) / 2), computed without overflow, and lane 1 is that value plus one. Done rises with these values and holds them until the next start pulse, which clears done on the following clock edge.
- R8: The pattern output for entry index i and word k (0 to 3) has bits 15:0 all ones when bit 2k of i is set and bits 31:16 all ones when bit 2k+1 of i is set. Every other bit is zero.
- R9: After reset, done and the check request are low and both lanes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle or done |
| start_tap | input | 6 | Tap the search starts from |
| check_req | output | 1 | One-cycle request for a check round |
| check_done | input | 1 | One-cycle answer from the checker |
| check_pass | input | 1 | Verdict, valid with check_done |
| lane0_tap | output | 6 | Delay tap for strobe lane 0 |
| lane1_tap | output | 6 | Delay tap for strobe lane 1 |
| done | output | 1 | Search finished, lanes hold the result |
| pat_index | input | 8 | Pattern entry index |
| pat_word | input | 2 | Word select within the entry |
| pat_data | output | 32 | Pattern word for the checker |

## Verification
The hardest case to reach is a trial whose first round passes and whose second round fails. The pass-window model alone never produces it. To reach it, the bench's checker responder counts how many times it has been asked about one chosen tap and answers fail on the second request for that tap. This tests that a fail in a late round ends the trial and sets the upper bound just below that tap. A second hard case is the ceiling, which is only reached when the pass window extends past tap 32. A wide window covers it, and the bench logs every requested tap to confirm the turn back to the start tap.

// File: rtl/dqs_tap_pkg.sv
package dqs_tap_pkg;
    localparam int TAP_W_DEF  = 6;
    localparam int CEIL_DEF   = 32;
    localparam int ROUNDS_DEF = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET,
        ST_REQ,
        ST_WAIT,
        ST_FIN,
        ST_DONE
    } srch_state_e;

    typedef enum logic {
        DIR_UP,
        DIR_DN
    } srch_dir_e;
endpackage

// File: rtl/tap_pattern_gen.sv
module tap_pattern_gen #(
    parameter int IDX_W  = 8,
    parameter int HALF_W = 16,
    parameter bit ENABLE = 1'b1,
    localparam int SEL_W  = $clog2(IDX_W / 2),
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] data
);
    generate
        if (ENABLE) begin : g_pat
            logic lo_bit, hi_bit;
            always_comb begin
                lo_bit = idx[2 * sel];
                hi_bit = idx[2 * sel + 1];
                data   = {{HALF_W{hi_bit}}, {HALF_W{lo_bit}}};
            end
        end else begin : g_nopat
            assign data = '0;
        end
    endgenerate
endmodule

// File: rtl/tap_midpoint.sv
module tap_midpoint #(
    parameter int TAP_W = 6
) (
    input  logic [TAP_W-1:0] upper,
    input  logic [TAP_W-1:0] lower,
    output logic [TAP_W-1:0] mid,
    output logic [TAP_W-1:0] mid_p1
);
    logic [TAP_W:0] sum;
    always_comb begin
        sum    = {1'b0, upper} + {1'b0, lower};
        mid    = sum[TAP_W:1];
        mid_p1 = sum[TAP_W:1] + 1'b1;
    end
endmodule

// File: rtl/tap_search_fsm.sv
module tap_search_fsm
    import dqs_tap_pkg::*;
#(
    parameter int TAP_W  = TAP_W_DEF,
    parameter int CEIL   = CEIL_DEF,
    parameter int ROUNDS = ROUNDS_DEF,
    localparam int RND_W = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAP_W-1:0] start_tap,
    input  logic             check_done,
    input  logic             check_pass,
    input  logic [TAP_W-1:0] mid,
    input  logic [TAP_W-1:0] mid_p1,
    output logic             check_req,
    output logic [TAP_W-1:0] lane0,
    output logic [TAP_W-1:0] lane1,
    output logic [TAP_W-1:0] upper,
    output logic [TAP_W-1:0] lower,
    output logic             done
);
    localparam logic [TAP_W-1:0] CEIL_V = TAP_W'(CEIL);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

    typedef struct packed {
        srch_state_e      st;
        srch_dir_e        dir;
        logic [TAP_W-1:0] cand;
        logic [TAP_W-1:0] origin;
        logic [TAP_W-1:0] upper;
        logic [TAP_W-1:0] lower;
        logic [RND_W-1:0] rnd;
        logic [TAP_W-1:0] lane0;
        logic [TAP_W-1:0] lane1;
        logic             req;
        logic             done;
    } srch_regs_t;

    srch_regs_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    r_d.st     = ST_SET;
                    r_d.dir    = DIR_UP;
                    r_d.cand   = start_tap;
                    r_d.origin = start_tap;
                    r_d.upper  = start_tap;
                    r_d.lower  = start_tap;
                    r_d.done   = 1'b0;
                end
            end
            ST_SET: begin
                r_d.lane0 = r_q.cand;
                r_d.lane1 = r_q.cand;
                r_d.rnd   = '0;
                r_d.st    = ST_REQ;
            end
            ST_REQ: begin
                r_d.req = 1'b1;
                r_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (check_done) begin
                    if (check_pass && r_q.rnd != LAST_RND) begin
                        r_d.rnd = r_q.rnd + 1'b1;
                        r_d.st  = ST_REQ;
                    end else if (r_q.dir == DIR_UP) begin
                        r_d.st = ST_SET;
                        if (check_pass && r_q.cand < CEIL_V) begin
                            r_d.cand = r_q.cand + 1'b1;
                        end else begin
                            r_d.upper = check_pass ? r_q.cand : r_q.cand - 1'b1;
                            r_d.dir   = DIR_DN;
                            r_d.cand  = r_q.origin;
                        end
                    end else begin
                        if (!check_pass) begin
                            r_d.lower = r_q.cand + 1'b1;
                            r_d.st    = ST_FIN;
                        end else if (r_q.cand == '0) begin
                            r_d.lower = '0;
                            r_d.st    = ST_FIN;
                        end else begin
                            r_d.cand = r_q.cand - 1'b1;
                            r_d.st   = ST_SET;
                        end
                    end
                end
            end
            ST_FIN: begin
                r_d.lane0 = mid;
                r_d.lane1 = mid_p1;
                r_d.done  = 1'b1;
                r_d.st    = ST_DONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, dir: DIR_UP, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign check_req = r_q.req;
    assign lane0     = r_q.lane0;
    assign lane1     = r_q.lane1;
    assign upper     = r_q.upper;
    assign lower     = r_q.lower;
    assign done      = r_q.done;

    p_req_lanes_eq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        check_req |-> lane0 == lane1);
    p_wait_lanes_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && !check_done) |=> ($stable(lane0) && $stable(lane1)));
    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        check_req |=> !check_req);
    p_up_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (check_req && r_q.dir == DIR_UP) |-> (lane0 <= CEIL_V || lane0 == r_q.origin));
    p_done_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lane1 == lane0 + 1'b1);
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(lane0) && $stable(lane1)));
endmodule

// File: rtl/dqs_tap_search.sv
module dqs_tap_search
    import dqs_tap_pkg::*;
#(
    parameter int TAP_W  = TAP_W_DEF,
    parameter int CEIL   = CEIL_DEF,
    parameter int ROUNDS = ROUNDS_DEF,
    parameter int IDX_W  = 8,
    parameter int HALF_W = 16,
    parameter bit PAT_EN = 1'b1,
    localparam int SEL_W  = $clog2(IDX_W / 2),
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAP_W-1:0]  start_tap,
    output logic              check_req,
    input  logic              check_done,
    input  logic              check_pass,
    output logic [TAP_W-1:0]  lane0_tap,
    output logic [TAP_W-1:0]  lane1_tap,
    output logic              done,
    input  logic [IDX_W-1:0]  pat_index,
    input  logic [SEL_W-1:0]  pat_word,
    output logic [DATA_W-1:0] pat_data
);
    logic [TAP_W-1:0] upper_w, lower_w, mid_w, mid_p1_w;

    tap_search_fsm #(
        .TAP_W (TAP_W),
        .CEIL  (CEIL),
        .ROUNDS(ROUNDS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_tap (start_tap),
        .check_done(check_done),
        .check_pass(check_pass),
        .mid       (mid_w),
        .mid_p1    (mid_p1_w),
        .check_req (check_req),
        .lane0     (lane0_tap),
        .lane1     (lane1_tap),
        .upper     (upper_w),
        .lower     (lower_w),
        .done      (done)
    );

    tap_midpoint #(.TAP_W(TAP_W)) u_mid (
        .upper (upper_w),
        .lower (lower_w),
        .mid   (mid_w),
        .mid_p1(mid_p1_w)
    );

    tap_pattern_gen #(
        .IDX_W (IDX_W),
        .HALF_W(HALF_W),
        .ENABLE(PAT_EN)
    ) u_pat (
        .idx (pat_index),
        .sel (pat_word),
        .data(pat_data)
    );
endmodule

// File: tb/dqs_tap_search_tb_top.sv
module dqs_tap_search_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  start_tap = '0;
    logic        check_req;
    logic        check_done = 1'b0;
    logic        check_pass = 1'b0;
    logic [5:0]  lane0_tap, lane1_tap;
    logic        done;
    logic [7:0]  pat_index = '0;
    logic [1:0]  pat_word = '0;
    logic [31:0] pat_data;

    int checks = 0;
    int failures = 0;
    int win_lo = 0, win_hi = 63, flaky_tap = -1, flaky_hits = 0;
    int req_cnt = 0, lane_mm = 0;
    int tap_log [0:127];

    always #2.5 clk = ~clk;

    dqs_tap_search dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_tap(start_tap),
        .check_req(check_req), .check_done(check_done), .check_pass(check_pass),
        .lane0_tap(lane0_tap), .lane1_tap(lane1_tap), .done(done),
        .pat_index(pat_index), .pat_word(pat_word), .pat_data(pat_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Checker model: passes taps inside [win_lo, win_hi], with an optional
    // fail on the second request seen for flaky_tap.
    initial begin
        forever begin
            @(negedge clk);
            if (check_req) begin
                int t;
                t = int'(lane0_tap);
                if (req_cnt < 128) tap_log[req_cnt] = t;
                req_cnt++;
                if (lane0_tap != lane1_tap) lane_mm++;
                if (t == flaky_tap) flaky_hits++;
                repeat (2) @(negedge clk);
                if (lane0_tap != lane1_tap) lane_mm++;
                check_pass = (t >= win_lo && t <= win_hi) && !(t == flaky_tap && flaky_hits == 2);
                check_done = 1'b1;
                @(negedge clk);
                check_done = 1'b0;
                check_pass = 1'b0;
            end
        end
    end

    task automatic run(input int s, input int lo, input int hi, input int fl,
                       input int exp0, input int exp1, input int expreq, input string req);
        int n;
        win_lo = lo; win_hi = hi; flaky_tap = fl; flaky_hits = 0;
        req_cnt = 0; lane_mm = 0;
        @(negedge clk);
        start = 1'b1; start_tap = 6'(s);
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R7 start clears done", done, 0);
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, {req, " watchdog/done"}, done, 1);
        check(lane0_tap == 6'(exp0), {req, " R7 lane0 midpoint"}, lane0_tap, exp0);
        check(lane1_tap == 6'(exp1), {req, " R7 lane1 offset"}, lane1_tap, exp1);
        check(req_cnt == expreq, {req, " R2 request count"}, req_cnt, expreq);
        check(lane_mm == 0, {req, " R1 lanes equal"}, lane_mm, 0);
    endtask

    task automatic t_reset;
        check(done == 1'b0, "R9 done after reset", done, 0);
        check(check_req == 1'b0, "R9 req after reset", check_req, 0);
        check(lane0_tap == 0 && lane1_tap == 0, "R9 lanes after reset", {lane0_tap, lane1_tap}, 0);
    endtask

    // Window [4,20] from 10: upper 20 (21 fails), lower 4 (3 fails) -> 12/13.
    task automatic t_mid_window;
        logic [5:0] held;
        run(10, 4, 20, -1, 12, 13, 38, "R4 R6");
        check(tap_log[22] == 21, "R3 up step reaches 21", tap_log[22], 21);
        check(tap_log[23] == 10, "R4 restart at start tap", tap_log[23], 10);
        check(tap_log[37] == 3, "R5 down step reaches 3", tap_log[37], 3);
        held = lane0_tap;
        repeat (6) @(negedge clk);
        check(done && lane0_tap == held, "R7 result held", lane0_tap, held);
    endtask

    // Window [0,50] from 8: ceiling at 32, lower 0 -> 16/17.
    task automatic t_ceiling_floor;
        run(8, 0, 50, -1, 16, 17, 68, "R3 R5");
        check(tap_log[48] == 32, "R3 ceiling tap tried", tap_log[48], 32);
        check(tap_log[50] == 8, "R3 restart after ceiling", tap_log[50], 8);
        check(tap_log[67] == 0, "R5 zero tap tried last", tap_log[67], 0);
    endtask

    // Start 40 above ceiling, window [35,60]: upper 40, lower 35 -> 37/38.
    task automatic t_above_ceiling;
        run(40, 35, 60, -1, 37, 38, 15, "R3 R6");
        check(tap_log[2] == 40, "R3 down restarts at start", tap_log[2], 40);
    endtask

    // Start 12 outside window: upper 11, lower 13 -> 12/13, two requests.
    task automatic t_start_fails;
        run(12, 20, 30, -1, 12, 13, 2, "R4 R6");
    endtask

    // Tap 9 passes round 1, fails round 2: upper 8, lower 0 -> 4/5.
    task automatic t_second_round_fail;
        run(5, 0, 20, 9, 4, 5, 22, "R2");
        check(tap_log[8] == 9 && tap_log[9] == 9, "R2 two rounds at tap 9", tap_log[9], 9);
        check(tap_log[10] == 5, "R2 fail in round 2 ends trial", tap_log[10], 5);
    endtask

    task automatic pat_chk(input int idx, input int w, input logic [31:0] exp);
        pat_index = 8'(idx); pat_word = 2'(w);
        #1;
        check(pat_data == exp, "R8 pattern word", pat_data, exp);
    endtask

    task automatic t_pattern;
        pat_chk(8'h00, 0, 32'h0000_0000);
        pat_chk(8'hFF, 3, 32'hFFFF_FFFF);
        pat_chk(8'h01, 0, 32'h0000_FFFF);
        pat_chk(8'h02, 0, 32'hFFFF_0000);
        pat_chk(8'h40, 3, 32'h0000_FFFF);
        pat_chk(8'h80, 3, 32'hFFFF_0000);
        pat_chk(8'h24, 1, 32'h0000_FFFF);
        pat_chk(8'h24, 2, 32'hFFFF_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pattern();
        t_mid_window();
        t_ceiling_floor();
        t_above_ceiling();
        t_start_fails();
        t_second_round_fail();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule